// File: doc/BRIEF.md
# Security Attribution Unit with Fault Syndrome

This block decides, for every memory access of a two-world processor, which security world the target address belongs to. Up to eight programmable windows, each a range of 32-byte granules, can hand an address to the Non-Secure world or mark it Non-Secure-Callable, where gateway entry stubs live. Every address that no window claims, and every address when attribution is switched off, belongs to the Secure world. Software therefore starts from a fully Secure map and opens holes for the Non-Secure side.

When a requester running in the Non-Secure state presents an access to a Secure address, the unit pulses a violation strobe. It records the event in a sticky syndrome word, with a violation flag at bit 3 and an address-valid flag at bit 6, and it captures the offending address. The address stays frozen while the valid flag is set, so a fault handler reads the first fault and not a later one. Software clears flags by writing ones to the syndrome word.

The attribution result and the strobe are registered and appear one clock after the address is presented. Configuration writes take effect at the clock edge that accepts them.

Top module: `sau_top`

## Requirements
- R1: After reset, attr_o is 0 (Secure), viol_o is 0, fault_status_o is 0x00, fault_addr_o is 0, attribution is disabled and every window is disabled.
- R2: While bit 0 of the control register (select 0) is 0, every address is attributed Secure (code 0), even if windows are programmed and enabled.
- R3: With attribution enabled, an address inside no enabled window is attributed Secure (code 0).
- R4: Window i takes its base granule from a write to select 16+2i (data bits 31:5) and its limit granule, enable (bit 0) and callable flag (bit 1) from a write to select 17+2i (limit in data bits 31:5). An address whose bits 31:5 lie between base and limit inclusive, in exactly one enabled window with the callable flag clear, is attributed Non-Secure (code 1).
- R5: The same single match with the callable flag set gives Non-Secure-Callable (code 2); code 3 never appears.
- R6: An address inside two or more enabled windows is attributed Secure (code 0).
- R7: viol_o is 1 in the cycle after an access with acc_valid=1 and acc_ns=1 whose address is attributed Secure, and is 0 otherwise: for Non-Secure or callable targets, Secure requesters, and cycles without acc_valid.
- R8: A violation sets fault_status_o bit 3 and bit 6 (reading 0x48) and loads fault_addr_o with the full access address, both in the same cycle as viol_o.
- R9: While bit 6 of fault_status_o stays set, further violations leave fault_addr_o unchanged and fault_status_o at 0x48.
- R10: A write to select 1 clears each fault_status_o bit whose data bit is 1 and leaves bits written 0 unchanged; a violation in the same cycle as the clear wins, setting both flags and capturing its address.
- R11: A window whose enable bit is 0 attributes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_ns | input | 1 | Requester runs in the Non-Secure state |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| attr_o | output | 2 | Attribution of the previous cycle's address: 0 Secure, 1 Non-Secure, 2 Non-Secure-Callable |
| viol_o | output | 1 | One-cycle attribution violation strobe |
| fault_status_o | output | 8 | Sticky syndrome: bit 3 violation, bit 6 address valid |
| fault_addr_o | output | ADDR_W | Captured faulting address |

## Verification
The hardest state to reach is a status-clear write landing on the very edge where a new violation arrives, since the outcome depends on which of the two updates the syndrome register honours. The bench drives the write strobe and a Non-Secure access to a Secure address from the same falling edge, so both meet the same rising edge, and then expects the flags set and the new address captured. Overlapping windows are reached by programming a second window that straddles the limit of the first, and probing inside the shared part and inside each exclusive part.

// File: rtl/sau_pkg.sv
package sau_pkg;

    typedef enum logic [1:0] {
        ATTR_S   = 2'd0,
        ATTR_NS  = 2'd1,
        ATTR_NSC = 2'd2
    } attr_e;

    localparam int STAT_W          = 8;
    localparam int STAT_VIOL_BIT   = 3;
    localparam int STAT_AVALID_BIT = 6;

    localparam int SEL_CTRL    = 0;
    localparam int SEL_STATUS  = 1;
    localparam int SEL_REGION0 = 16;

endpackage

// File: rtl/sau_region.sv
module sau_region #(
    parameter int GW = 27
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_base,
    input  logic          wr_limit,
    input  logic [GW-1:0] wr_gran,
    input  logic          wr_en_bit,
    input  logic          wr_nsc_bit,
    input  logic [GW-1:0] probe_gran,
    output logic          hit,
    output logic          nsc
);

    typedef struct packed {
        logic [GW-1:0] base;
        logic [GW-1:0] limit;
        logic          en;
        logic          nsc;
    } region_t;

    region_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_base) begin
            r_d.base = wr_gran;
        end
        if (wr_limit) begin
            r_d.limit = wr_gran;
            r_d.en    = wr_en_bit;
            r_d.nsc   = wr_nsc_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        hit = r_q.en && (probe_gran >= r_q.base) && (probe_gran <= r_q.limit);
        nsc = r_q.nsc;
    end

endmodule

// File: rtl/sau_resolve.sv
module sau_resolve
    import sau_pkg::*;
#(
    parameter int NUM_REGIONS = 8
) (
    input  logic [NUM_REGIONS-1:0] hit,
    input  logic [NUM_REGIONS-1:0] nsc,
    input  logic                   enable,
    output attr_e                  attr
);

    logic single_hit;
    logic callable;

    always_comb begin
        single_hit = ($countones(hit) == 1);
        callable   = |(hit & nsc);
        if (!enable || !single_hit) begin
            attr = ATTR_S;
        end else if (callable) begin
            attr = ATTR_NSC;
        end else begin
            attr = ATTR_NS;
        end
    end

endmodule

// File: rtl/sau_syndrome.sv
module sau_syndrome
    import sau_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              viol,
    input  logic [ADDR_W-1:0] viol_addr,
    input  logic              clr_we,
    input  logic [STAT_W-1:0] clr_mask,
    output logic [STAT_W-1:0] status,
    output logic [ADDR_W-1:0] fault_addr
);

    typedef struct packed {
        logic [STAT_W-1:0] status;
        logic [ADDR_W-1:0] addr;
    } synd_t;

    synd_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_we) begin
            s_d.status = s_q.status & ~clr_mask;
        end
        if (viol) begin
            s_d.status[STAT_VIOL_BIT] = 1'b1;
            if (!s_d.status[STAT_AVALID_BIT]) begin
                s_d.status[STAT_AVALID_BIT] = 1'b1;
                s_d.addr                    = viol_addr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status     = s_q.status;
    assign fault_addr = s_q.addr;

endmodule

// File: rtl/sau_top.sv
module sau_top
    import sau_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int NUM_REGIONS = 8,
    parameter int GRAN_BITS   = 5,
    parameter int SEL_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_ns,
    input  logic              cfg_we,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [1:0]        attr_o,
    output logic              viol_o,
    output logic [7:0]        fault_status_o,
    output logic [ADDR_W-1:0] fault_addr_o
);

    localparam int GW = ADDR_W - GRAN_BITS;

    typedef struct packed {
        logic  en;
        attr_e attr;
        logic  viol;
    } top_t;

    top_t st_d, st_q;

    logic [NUM_REGIONS-1:0] hit;
    logic [NUM_REGIONS-1:0] nsc;
    attr_e                  attr_now;
    logic                   viol_now;
    logic                   stat_clr;

    // One comparator per window; each decodes its own pair of selects.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        logic wr_b, wr_l;
        assign wr_b = cfg_we && (cfg_sel == SEL_W'(SEL_REGION0 + 2 * g));
        assign wr_l = cfg_we && (cfg_sel == SEL_W'(SEL_REGION0 + 2 * g + 1));
        sau_region #(
            .GW (GW)
        ) u_region (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_base    (wr_b),
            .wr_limit   (wr_l),
            .wr_gran    (cfg_wdata[ADDR_W-1:GRAN_BITS]),
            .wr_en_bit  (cfg_wdata[0]),
            .wr_nsc_bit (cfg_wdata[1]),
            .probe_gran (acc_addr[ADDR_W-1:GRAN_BITS]),
            .hit        (hit[g]),
            .nsc        (nsc[g])
        );
    end

    sau_resolve #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_resolve (
        .hit    (hit),
        .nsc    (nsc),
        .enable (st_q.en),
        .attr   (attr_now)
    );

    assign viol_now = acc_valid && acc_ns && (attr_now == ATTR_S);
    assign stat_clr = cfg_we && (cfg_sel == SEL_W'(SEL_STATUS));

    always_comb begin
        st_d      = st_q;
        st_d.attr = attr_now;
        st_d.viol = viol_now;
        if (cfg_we && (cfg_sel == SEL_W'(SEL_CTRL))) begin
            st_d.en = cfg_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    sau_syndrome #(
        .ADDR_W (ADDR_W)
    ) u_syndrome (
        .clk        (clk),
        .rst_n      (rst_n),
        .viol       (viol_now),
        .viol_addr  (acc_addr),
        .clr_we     (stat_clr),
        .clr_mask   (cfg_wdata[STAT_W-1:0]),
        .status     (fault_status_o),
        .fault_addr (fault_addr_o)
    );

    assign attr_o = st_q.attr;
    assign viol_o = st_q.viol;

endmodule

// File: rtl/sau_top_chk.sv
module sau_top_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ns,
    input logic              stat_wr,
    input logic              clr_viol,
    input logic              clr_av,
    input logic              en_q,
    input logic [1:0]        attr_o,
    input logic              viol_o,
    input logic [7:0]        fault_status_o,
    input logic [ADDR_W-1:0] fault_addr_o
);

    assert_disabled_secure_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_q) |-> (attr_o == 2'd0));

    assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        attr_o != 2'd3);

    assert_strobe_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> $past(acc_valid && acc_ns));

    assert_strobe_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |-> (fault_status_o == 8'h48));

    assert_addr_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fault_status_o[6]) && !$past(stat_wr && clr_av)) |-> $stable(fault_addr_o));

    assert_clear_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_wr && clr_viol) && !viol_o) |-> !fault_status_o[3]);

endmodule

bind sau_top sau_top_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .acc_valid      (acc_valid),
    .acc_ns         (acc_ns),
    .stat_wr        (cfg_we && (cfg_sel == SEL_W'(sau_pkg::SEL_STATUS))),
    .clr_viol       (cfg_wdata[3]),
    .clr_av         (cfg_wdata[6]),
    .en_q           (st_q.en),
    .attr_o         (attr_o),
    .viol_o         (viol_o),
    .fault_status_o (fault_status_o),
    .fault_addr_o   (fault_addr_o)
);

// File: tb/sau_top_bench.sv
module sau_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_ns = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic [1:0]  attr_o;
    logic        viol_o;
    logic [7:0]  fault_status_o;
    logic [31:0] fault_addr_o;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    sau_top u_sau_top (
        .clk            (clk),
        .rst_n          (rst_n),
        .acc_valid      (acc_valid),
        .acc_addr       (acc_addr),
        .acc_ns         (acc_ns),
        .cfg_we         (cfg_we),
        .cfg_sel        (cfg_sel),
        .cfg_wdata      (cfg_wdata),
        .attr_o         (attr_o),
        .viol_o         (viol_o),
        .fault_status_o (fault_status_o),
        .fault_addr_o   (fault_addr_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg_wr(input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = sel[4:0];
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic set_region(input int i, input logic [31:0] base, input logic [31:0] lim,
                              input logic en, input logic nsc);
        cfg_wr(16 + 2 * i, base);
        cfg_wr(17 + 2 * i, {lim[31:5], 3'b000, nsc, en});
    endtask

    // Presents one access; returns at the falling edge after the accepting edge.
    task automatic access(input logic [31:0] a, input logic ns, input logic v);
        @(negedge clk);
        acc_addr  = a;
        acc_ns    = ns;
        acc_valid = v;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 attr", {30'd0, attr_o}, 32'd0);
        chk("R1 viol", {31'd0, viol_o}, 32'd0);
        chk("R1 status", {24'd0, fault_status_o}, 32'd0);
        chk("R1 addr", fault_addr_o, 32'd0);
    endtask

    task automatic t_disabled;
        set_region(0, 32'h2000_0000, 32'h2000_0FE0, 1'b1, 1'b0);
        access(32'h2000_0100, 1'b0, 1'b1);
        chk("R2 disabled unit gives Secure", {30'd0, attr_o}, 32'd0);
    endtask

    task automatic t_single;
        cfg_wr(0, 32'h1);
        access(32'h2000_0000, 1'b0, 1'b1);
        chk("R4 base edge", {30'd0, attr_o}, 32'd1);
        access(32'h2000_0FFF, 1'b0, 1'b1);
        chk("R4 limit last byte", {30'd0, attr_o}, 32'd1);
        access(32'h2000_1000, 1'b0, 1'b1);
        chk("R3 past limit", {30'd0, attr_o}, 32'd0);
        access(32'h1FFF_FFFF, 1'b0, 1'b1);
        chk("R3 below base", {30'd0, attr_o}, 32'd0);
        set_region(3, 32'h3000_0000, 32'h3000_0FE0, 1'b0, 1'b0);
        access(32'h3000_0010, 1'b0, 1'b1);
        chk("R11 disabled window", {30'd0, attr_o}, 32'd0);
    endtask

    task automatic t_nsc;
        set_region(1, 32'h1000_0000, 32'h1000_0FE0, 1'b1, 1'b1);
        access(32'h1000_0800, 1'b0, 1'b1);
        chk("R5 callable", {30'd0, attr_o}, 32'd2);
    endtask

    task automatic t_overlap;
        set_region(2, 32'h2000_0800, 32'h2000_1FE0, 1'b1, 1'b0);
        access(32'h2000_0900, 1'b0, 1'b1);
        chk("R6 overlap Secure", {30'd0, attr_o}, 32'd0);
        access(32'h2000_1800, 1'b0, 1'b1);
        chk("R6 second window alone", {30'd0, attr_o}, 32'd1);
        access(32'h2000_0100, 1'b0, 1'b1);
        chk("R6 first window alone", {30'd0, attr_o}, 32'd1);
    endtask

    task automatic t_noviol;
        access(32'h2000_0100, 1'b1, 1'b1);
        chk("R7 NS to NS", {31'd0, viol_o}, 32'd0);
        access(32'h1000_0800, 1'b1, 1'b1);
        chk("R7 NS to callable", {31'd0, viol_o}, 32'd0);
        access(32'h4000_0000, 1'b0, 1'b1);
        chk("R7 Secure requester", {31'd0, viol_o}, 32'd0);
        access(32'h4000_0000, 1'b1, 1'b0);
        chk("R7 no valid", {31'd0, viol_o}, 32'd0);
        chk("R7 status untouched", {24'd0, fault_status_o}, 32'd0);
    endtask

    task automatic t_viol;
        access(32'h4000_0044, 1'b1, 1'b1);
        chk("R7 strobe", {31'd0, viol_o}, 32'd1);
        chk("R8 status", {24'd0, fault_status_o}, 32'h48);
        chk("R8 address", fault_addr_o, 32'h4000_0044);
        @(negedge clk);
        chk("R7 strobe one cycle", {31'd0, viol_o}, 32'd0);
    endtask

    task automatic t_sticky;
        access(32'h5000_0000, 1'b1, 1'b1);
        chk("R9 second strobe", {31'd0, viol_o}, 32'd1);
        chk("R9 address held", fault_addr_o, 32'h4000_0044);
        chk("R9 status", {24'd0, fault_status_o}, 32'h48);
    endtask

    task automatic t_w1c;
        cfg_wr(1, 32'h0);
        chk("R10 zero write", {24'd0, fault_status_o}, 32'h48);
        cfg_wr(1, 32'h40);
        chk("R10 clear valid only", {24'd0, fault_status_o}, 32'h08);
        access(32'h6000_0000, 1'b1, 1'b1);
        chk("R10 recapture", fault_addr_o, 32'h6000_0000);
        chk("R10 status again", {24'd0, fault_status_o}, 32'h48);
        cfg_wr(1, 32'h48);
        chk("R10 clear all", {24'd0, fault_status_o}, 32'h00);
        cfg_wr(1, 32'h48);
        access(32'h6000_0000, 1'b1, 1'b1);
        // clear and violation on the same edge
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 5'd1;
        cfg_wdata = 32'h48;
        acc_addr  = 32'h7000_0000;
        acc_ns    = 1'b1;
        acc_valid = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
        acc_valid = 1'b0;
        chk("R10 violation wins status", {24'd0, fault_status_o}, 32'h48);
        chk("R10 violation wins address", fault_addr_o, 32'h7000_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_single();
        t_nsc();
        t_overlap();
        t_noviol();
        t_viol();
        t_sticky();
        t_w1c();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

endmodule